// File: doc/BRIEF.md
# Two-Wire Bus Byte Shifter

This block is the eight-bit data register of a two-wire serial bus controller. A host loads a byte in parallel. The block then sends it one bit per clock pulse, most significant bit first. The bus line is sampled on every bit clock, in both directions, and that sample fills the vacated low bit. After each byte the register therefore holds what actually appeared on the wire, not what the block tried to drive.

Two consequences follow from this, and the surrounding controller relies on both:

- **Arbitration loss needs no reload.** If the block loses arbitration while transmitting, the register already contains the received byte. The controller can continue as a slave receiver without reloading it.
- **Loss is flagged directly.** A sticky flag marks any transmit bit where the block released the line high but sampled it low.

A bit counter raises a one-cycle strobe when eight bits have moved. The counter then lets the ninth (acknowledge) clock pass without shifting.

The controller drives the other inputs:

- a shift enable, one cycle long, aligned with each rising edge of the serial clock;
- the sampled data level;
- a transmit/receive select;
- a start indication, which restarts bit counting.

Top module: `i2c_byte_shifter`

## Requirements
- R1: After reset the register reads 0x00, the strobe and the loss flag are low, and the data output is high (released).
- R2: A load places load_data[7:0] in the register on the next clock edge; bits above 7 have no effect. A load also clears the bit count, the acknowledge phase and the loss flag. A load takes priority over a shift in the same cycle.
- R3: In transmit mode, outside the acknowledge phase, the data output equals register bit 7. The bits of a loaded byte therefore appear on the line from bit 7 down to bit 0.
- R4: On each shift enable outside the acknowledge phase, the register moves one place toward bit 7 and takes the sampled level into bit 0. After eight shifts, the first sampled bit sits in bit 7.
- R5: In transmit mode the register captures the sampled level, not the driven one. After eight bits it holds the byte seen on the bus.
- R6: byte_done is high for exactly one cycle, in the cycle after the clock edge that performs the eighth shift. It stays low after the first seven shifts.
- R7: The shift enable that follows the eighth shift is the acknowledge clock: the register keeps its value and the bit count does not advance. Shifting resumes on the next shift enable.
- R8: arb_lost becomes set on a shift when all of these hold: transmit mode is selected, the block is outside the acknowledge phase, register bit 7 is 1, and the sampled level is 0. It is never set when the driven bit is 0, and never in receive mode. Once set, it stays set until a load or a start.
- R9: A start clears the bit count, the acknowledge phase and the loss flag, and leaves the register contents unchanged. After a start, eight further shifts are needed before byte_done.
- R10: The data output is high in receive mode and during the acknowledge phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Parallel load strobe |
| load_data | input | HOST_W | Host write word; only bits 7..0 are used |
| start_seen | input | 1 | Start condition detected on the bus |
| shift_en | input | 1 | One-cycle pulse per serial clock rising edge |
| sda_in | input | 1 | Sampled data line level |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| sda_out | output | 1 | Level to drive on the data line (1 = release) |
| rd_data | output | 8 | Register contents for host reads |
| byte_done | output | 1 | One-cycle strobe after the eighth shift |
| arb_lost | output | 1 | Sticky flag: released high but sampled low |

## Verification
The bench feeds the bus a byte that differs from the loaded one.

- **Bus value capture.** The register must end with the bus byte. A design that captured its own driven bit would keep the loaded value.
- **Acknowledge clock.** The ninth shift enable must leave the register untouched. A counter that wraps without an acknowledge phase would shift in the acknowledge bit and misalign the next byte.
- **Loss-flag polarity.** Driven-low-sampled-high bits, and receive mode, must leave the flag clear. A flag built on plain inequality would fire falsely in both cases.
- **Count restart.** A start partway through a byte must restart the count. A design that ignored it would strobe early.

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter #(
  parameter int HOST_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [HOST_W-1:0] load_data,
  input  logic              start_seen,
  input  logic              shift_en,
  input  logic              sda_in,
  input  logic              tx_mode,
  output logic              sda_out,
  output logic [7:0]        rd_data,
  output logic              byte_done,
  output logic              arb_lost
);

  logic [7:0] data_q;
  logic [2:0] bit_cnt;
  logic       in_ack;
  logic       done_q;
  logic       arb_q;
  logic       unused_hi;

  assign unused_hi = ^load_data[HOST_W-1:8];

  wire data_shift = shift_en && !in_ack && !load;
  wire last_bit   = (bit_cnt == 3'd7);
  wire clash      = data_shift && tx_mode && data_q[7] && !sda_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= 8'h00;
      bit_cnt <= 3'd0;
      in_ack  <= 1'b0;
      done_q  <= 1'b0;
      arb_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        data_q  <= load_data[7:0];
        bit_cnt <= 3'd0;
        in_ack  <= 1'b0;
        arb_q   <= 1'b0;
      end else if (start_seen) begin
        bit_cnt <= 3'd0;
        in_ack  <= 1'b0;
        arb_q   <= 1'b0;
      end else if (shift_en) begin
        if (in_ack) begin
          in_ack <= 1'b0;
        end else begin
          data_q  <= {data_q[6:0], sda_in};
          bit_cnt <= bit_cnt + 3'd1;
          if (last_bit) begin
            done_q <= 1'b1;
            in_ack <= 1'b1;
          end
          if (clash) arb_q <= 1'b1;
        end
      end
    end
  end

  assign sda_out   = (tx_mode && !in_ack) ? data_q[7] : 1'b1;
  assign rd_data   = data_q;
  assign byte_done = done_q;
  assign arb_lost  = arb_q;

endmodule

// File: rtl/i2c_byte_shifter_chk.sv
module i2c_byte_shifter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       load,
  input logic [7:0] load_low,
  input logic       start_seen,
  input logic       shift_en,
  input logic       sda_in,
  input logic       tx_mode,
  input logic       sda_out,
  input logic [7:0] rd_data,
  input logic       byte_done,
  input logic       arb_lost,
  input logic       in_ack
);

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> rd_data == $past(load_low));

  // R4
  shift_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !in_ack && !load && !start_seen) |=> rd_data[0] == $past(sda_in));

  // R7
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && in_ack && !load) |=> $stable(rd_data));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done);

  // R10
  release_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_mode |-> sda_out);

  // R8
  arb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> $past(tx_mode && shift_en && !sda_in && sda_out));

  // R9
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_seen && !load) |=> !arb_lost && $stable(rd_data));

endmodule

bind i2c_byte_shifter i2c_byte_shifter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .load_low(load_data[7:0]),
  .start_seen(start_seen), .shift_en(shift_en), .sda_in(sda_in),
  .tx_mode(tx_mode), .sda_out(sda_out), .rd_data(rd_data),
  .byte_done(byte_done), .arb_lost(arb_lost), .in_ack(in_ack)
);

// File: tb/tb_i2c_byte_shifter.sv
module tb_i2c_byte_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [31:0] load_data = '0;
  logic        start_seen = 1'b0;
  logic        shift_en = 1'b0;
  logic        sda_in = 1'b1;
  logic        tx_mode = 1'b0;
  logic        sda_out;
  logic [7:0]  rd_data;
  logic        byte_done;
  logic        arb_lost;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  i2c_byte_shifter #(.HOST_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(load_data),
    .start_seen(start_seen), .shift_en(shift_en), .sda_in(sda_in),
    .tx_mode(tx_mode), .sda_out(sda_out), .rd_data(rd_data),
    .byte_done(byte_done), .arb_lost(arb_lost)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [31:0] w);
    @(negedge clk); load = 1'b1; load_data = w;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk); start_seen = 1'b1;
    @(negedge clk); start_seen = 1'b0;
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk); shift_en = 1'b1; sda_in = b;
    @(negedge clk); shift_en = 1'b0; sda_in = 1'b1;
  endtask

  task automatic t_reset();
    check("R1 data", rd_data, 8'h00);
    check("R1 done", byte_done, 0);
    check("R1 arb", arb_lost, 0);
    check("R1 sda", sda_out, 1);
  endtask

  task automatic t_load_upper();
    tx_mode = 1'b0;
    do_load(32'hDEAD_BE5A);
    check("R2 low byte", rd_data, 8'h5A);
    check("R10 rx release", sda_out, 1);
  endtask

  task automatic t_loopback_tx();
    logic [7:0] v = 8'h3C;
    tx_mode = 1'b1;
    do_load({24'hFFFFFF, v});
    for (int i = 7; i >= 0; i--) begin
      check("R3 msb first", sda_out, v[i]);
      check("R6 no early done", byte_done, 0);
      shift_bit(sda_out);
    end
    check("R6 done pulse", byte_done, 1);
    check("R4 loopback data", rd_data, v);
    check("R8 no arb on match", arb_lost, 0);
    check("R10 ack release", sda_out, 1);
    @(negedge clk);
    check("R6 one cycle", byte_done, 0);
    shift_bit(1'b0);
    check("R7 ack no shift", rd_data, v);
    check("R3 after ack", sda_out, v[7]);
    shift_bit(1'b1);
    check("R7 shift resumes", rd_data, 8'h79);
  endtask

  task automatic t_capture_bus();
    logic [7:0] bus = 8'hE1;
    tx_mode = 1'b1;
    do_load(32'h0000_00A5);
    for (int i = 7; i >= 0; i--) shift_bit(bus[i]);
    check("R5 bus byte", rd_data, bus);
    check("R8 arb set", arb_lost, 1);
    shift_bit(1'b1);
    check("R8 arb sticky", arb_lost, 1);
    do_start();
    check("R9 start clears arb", arb_lost, 0);
    check("R9 start keeps data", rd_data, bus);
  endtask

  task automatic t_no_false_arb();
    tx_mode = 1'b1;
    do_load(32'h0);
    for (int i = 0; i < 8; i++) shift_bit(1'b1);
    check("R8 low drive high bus", arb_lost, 0);
    check("R5 ones captured", rd_data, 8'hFF);
    tx_mode = 1'b0;
    do_load(32'h0000_00FF);
    for (int i = 0; i < 8; i++) shift_bit(1'b0);
    check("R8 rx no arb", arb_lost, 0);
    check("R4 rx zeros", rd_data, 8'h00);
  endtask

  task automatic t_rx_order();
    logic [7:0] bus = 8'h96;
    tx_mode = 1'b0;
    do_load(32'h0);
    for (int i = 7; i >= 0; i--) begin
      check("R10 rx sda", sda_out, 1);
      shift_bit(bus[i]);
    end
    check("R4 first bit in bit7", rd_data, bus);
    check("R6 rx done", byte_done, 1);
  endtask

  task automatic t_restart();
    tx_mode = 1'b0;
    do_load(32'h0);
    for (int i = 0; i < 3; i++) shift_bit(1'b1);
    do_start();
    for (int i = 0; i < 7; i++) shift_bit(1'b0);
    check("R9 no early done", byte_done, 0);
    shift_bit(1'b1);
    check("R9 done after eight", byte_done, 1);
    check("R9 data", rd_data, 8'h01);
    for (int i = 0; i < 5; i++) shift_bit(1'b1);
    do_load(32'h0000_0011);
    check("R2 load clears ack", rd_data, 8'h11);
    shift_bit(1'b0);
    check("R2 shifts after load", rd_data, 8'h22);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_load_upper();
    t_loopback_tx();
    t_capture_bus();
    t_no_false_arb();
    t_rx_order();
    t_restart();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule